// File: doc/BRIEF.md
# Aligned Eight-Byte Flash Write Gatherer

This block sits between register-access logic and a flash programming port. Software writes single bytes at byte addresses, and flash accepts only whole 8-byte groups. The block gathers the bytes of one group into a 64-bit word. When the group is complete it raises a program request carrying that word and the aligned start address. It then waits for the flash side to acknowledge.

A group must open on an address whose low three bits are zero. The group must lie inside the flash window, 0x200 to 0x3FF, which covers both flash sub-pages. Each later byte must target the address one above the previous byte. Idle cycles between writes are allowed. Any write that breaks these rules is refused, and a sticky error flag records it. The flag stays set until a clear input is pulsed.

Top module: `flash_group_gatherer`

## Requirements
- R1: After reset, `progReq`, `busy` and `err` are all 0.
- R2: A write at an address whose bits [2:0] are 000, with the whole group inside 0x200..0x3FF, opens a group. After seven more writes to the addresses that follow it, `progReq` and `busy` rise on the clock edge that takes the eighth byte. `progAddr` then holds the group start address.
- R3: In `progData`, the byte written at start address + i sits in bits [8i+7:8i], so the byte at the lowest address is in the least significant byte.
- R4: A first write whose address bits [2:0] are not 000 opens no group and sets `err` on the same clock edge.
- R5: A first write at an address below 0x200 opens no group and sets `err`.
- R6: Within an open group, a write to any address other than the expected next one drops the partial group and sets `err`. The next aligned group is then gathered from its own bytes only.
- R7: Cycles with `wrEn` low between the bytes of a group do not break the group.
- R8: While `progReq` is high and `progAck` is low, `progReq`, `busy`, `progAddr` and `progData` hold their values. One clock edge with `progAck` high drops `progReq` and `busy` on that edge.
- R9: A write while `busy` is high leaves `progData` and `progAddr` unchanged and sets `err`.
- R10: `err` stays set until `errClr` is sampled high. If `errClr` arrives on the same edge as a new error, the error wins and `err` stays 1.
- R11: A `progAck` pulse while no request is pending has no effect: a group being gathered still completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 10 | Byte address of the write |
| wrData | input | 8 | Byte being written |
| errClr | input | 1 | Clears the sticky error flag |
| progAck | input | 1 | Flash side has taken the pending word |
| progReq | output | 1 | A complete group is waiting to be programmed |
| progAddr | output | 10 | Start address of the pending group |
| progData | output | 64 | Gathered group, lowest address in the least significant byte |
| busy | output | 1 | Waiting for `progAck`; writes are refused |
| err | output | 1 | Sticky sequence-error flag |

## Verification
The bench runs groups at both ends of the window and groups with idle gaps between bytes. A design that counted cycles instead of writes would fail the gapped groups. It also sends an unaligned opener, an opener below the window, and a wrong address in the middle of a group. A design that skipped these checks would raise a request for a malformed group, or would mix stale bytes into the next one. A write during the busy window shows whether the held word gets corrupted. A stray acknowledge and a clear that coincides with an error show whether the handshake and the flag priorities are inverted.

// File: rtl/fgat_pkg.sv
package fgat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_PROG   = 2'd2
  } fgatState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBase;   // latch group start address
    logic capture;    // store wrData into the current lane
    logic clearLanes; // wipe gathered bytes after a dropped group
  } fgatStrobe_t;

endpackage

// File: rtl/fgat_dpath.sv
module fgat_dpath
  import fgat_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int GROUP_BYTES = 8,
  parameter int PAGE_LO     = 'h200,
  parameter int PAGE_HI     = 'h3FF,
  localparam int LANE_W     = $clog2(GROUP_BYTES),
  localparam int WORD_W     = GROUP_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fgatStrobe_t       strb,
  input  logic [LANE_W-1:0] laneIdx,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output logic              startOk,
  output logic              nextOk,
  output logic [ADDR_W-1:0] progAddr,
  output logic [WORD_W-1:0] progData
);

  localparam int EXT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] baseAddr;
  logic [EXT_W-1:0]  addrExt;
  logic [EXT_W-1:0]  lastExt;
  logic              aligned;
  logic              inWindow;
  logic [ADDR_W-1:0] expAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
    end else if (strb.loadBase) begin
      baseAddr <= wrAddr;
    end
  end

  // one byte register per lane
  for (genvar g = 0; g < GROUP_BYTES; g++) begin : gLane
    logic [7:0] laneByte;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneByte <= '0;
      end else if (strb.clearLanes) begin
        laneByte <= '0;
      end else if (strb.capture && (laneIdx == LANE_W'(g))) begin
        laneByte <= wrData;
      end
    end
    assign progData[g*8 +: 8] = laneByte;
  end

  always_comb begin
    addrExt  = {1'b0, wrAddr};
    lastExt  = addrExt + EXT_W'(GROUP_BYTES - 1);
    aligned  = (wrAddr[LANE_W-1:0] == '0);
    inWindow = (addrExt >= EXT_W'(PAGE_LO)) && (lastExt <= EXT_W'(PAGE_HI));
    startOk  = aligned && inWindow;
    expAddr  = baseAddr + ADDR_W'(laneIdx);
    nextOk   = (wrAddr == expAddr);
  end

  assign progAddr = baseAddr;

endmodule

// File: rtl/fgat_ctrl.sv
module fgat_ctrl
  import fgat_pkg::*;
#(
  parameter int GROUP_BYTES = 8,
  localparam int LANE_W     = $clog2(GROUP_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              errClr,
  input  logic              progAck,
  input  logic              startOk,
  input  logic              nextOk,
  output fgatStrobe_t       strb,
  output logic [LANE_W-1:0] laneIdx,
  output logic              progReq,
  output logic              busy,
  output logic              err
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(GROUP_BYTES - 1);

  fgatState_t        state, nextState;
  logic [LANE_W-1:0] lane, nextLane;
  logic              errEvt;

  always_comb begin
    strb      = '0;
    errEvt    = 1'b0;
    nextState = state;
    nextLane  = lane;
    case (state)
      ST_IDLE: begin
        if (wrEn) begin
          if (startOk) begin
            strb.loadBase = 1'b1;
            strb.capture  = 1'b1;
            nextLane      = LANE_W'(1);
            nextState     = ST_GATHER;
          end else begin
            errEvt = 1'b1;
          end
        end
      end
      ST_GATHER: begin
        if (wrEn) begin
          if (nextOk) begin
            strb.capture = 1'b1;
            if (lane == LAST_LANE) begin
              nextLane  = '0;
              nextState = ST_PROG;
            end else begin
              nextLane = lane + LANE_W'(1);
            end
          end else begin
            errEvt          = 1'b1;
            strb.clearLanes = 1'b1;
            nextLane        = '0;
            nextState       = ST_IDLE;
          end
        end
      end
      ST_PROG: begin
        if (wrEn) begin
          errEvt = 1'b1;
        end
        if (progAck) begin
          nextState = ST_IDLE;
        end
      end
      default: begin
        nextState = ST_IDLE;
        nextLane  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      lane  <= '0;
    end else begin
      state <= nextState;
      lane  <= nextLane;
    end
  end

  // sticky flag, a new error outranks a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      err <= 1'b0;
    end else if (errEvt) begin
      err <= 1'b1;
    end else if (errClr) begin
      err <= 1'b0;
    end
  end

  assign laneIdx = lane;
  assign progReq = (state == ST_PROG);
  assign busy    = (state == ST_PROG);

endmodule

// File: rtl/flash_group_gatherer.sv
module flash_group_gatherer
  import fgat_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int GROUP_BYTES = 8,
  parameter int PAGE_LO     = 'h200,
  parameter int PAGE_HI     = 'h3FF,
  localparam int LANE_W     = $clog2(GROUP_BYTES),
  localparam int WORD_W     = GROUP_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              errClr,
  input  logic              progAck,
  output logic              progReq,
  output logic [ADDR_W-1:0] progAddr,
  output logic [WORD_W-1:0] progData,
  output logic              busy,
  output logic              err
);

  fgatStrobe_t       strb;
  logic [LANE_W-1:0] laneIdx;
  logic              startOk;
  logic              nextOk;

  fgat_ctrl #(
    .GROUP_BYTES(GROUP_BYTES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .errClr (errClr),
    .progAck(progAck),
    .startOk(startOk),
    .nextOk (nextOk),
    .strb   (strb),
    .laneIdx(laneIdx),
    .progReq(progReq),
    .busy   (busy),
    .err    (err)
  );

  fgat_dpath #(
    .ADDR_W     (ADDR_W),
    .GROUP_BYTES(GROUP_BYTES),
    .PAGE_LO    (PAGE_LO),
    .PAGE_HI    (PAGE_HI)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .laneIdx (laneIdx),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .startOk (startOk),
    .nextOk  (nextOk),
    .progAddr(progAddr),
    .progData(progData)
  );

endmodule

// File: rtl/fgat_chk.sv
module fgat_chk #(
  parameter int ADDR_W      = 10,
  parameter int GROUP_BYTES = 8,
  parameter int PAGE_LO     = 'h200,
  parameter int PAGE_HI     = 'h3FF,
  localparam int LANE_W     = $clog2(GROUP_BYTES),
  localparam int WORD_W     = GROUP_BYTES * 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              errClr,
  input logic              progAck,
  input logic              progReq,
  input logic [ADDR_W-1:0] progAddr,
  input logic [WORD_W-1:0] progData,
  input logic              busy,
  input logic              err
);

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> (progAddr[LANE_W-1:0] == '0)); // R2

  AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> ((int'(progAddr) >= PAGE_LO) && (int'(progAddr) + GROUP_BYTES - 1 <= PAGE_HI))); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (progReq && !progAck) |=> (progReq && busy && $stable(progData) && $stable(progAddr))); // R8

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (progReq && progAck) |=> (!progReq && !busy)); // R8

  AST_BUSY_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> err); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (err && !errClr) |=> err); // R10

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !wrEn) |=> !err); // R10

endmodule

bind flash_group_gatherer fgat_chk #(
  .ADDR_W     (ADDR_W),
  .GROUP_BYTES(GROUP_BYTES),
  .PAGE_LO    (PAGE_LO),
  .PAGE_HI    (PAGE_HI)
) u_chk (.*);

// File: tb/flash_group_gatherer_tb.sv
`timescale 1ns/1ps
module flash_group_gatherer_tb;

  typedef struct {
    logic [9:0]  addr;
    logic [63:0] data;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [9:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        errClr = 1'b0;
  logic        monAck = 1'b0;
  logic        strayAck = 1'b0;
  logic        progAck;
  logic        progReq;
  logic [9:0]  progAddr;
  logic [63:0] progData;
  logic        busy;
  logic        err;

  int checks = 0;
  int errors = 0;
  int ackDelay = 1;
  int reqSeen = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  assign progAck = monAck | strayAck;

  always #2 clk = ~clk; // 250 MHz

  flash_group_gatherer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .errClr(errClr), .progAck(progAck), .progReq(progReq), .progAddr(progAddr),
    .progData(progData), .busy(busy), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clearErr();
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  // driver: pushes the expected group, then writes its bytes
  task automatic sendGroup(input logic [9:0] base, input logic [7:0] seed, input int gap);
    expItem_t it;
    it.addr = base;
    for (int i = 0; i < 8; i++) it.data[i*8 +: 8] = seed + 8'(i * 'h11);
    expQ.push_back(it);
    for (int i = 0; i < 8; i++) begin
      wr(base + 10'(i), it.data[i*8 +: 8]);
      if (i < 7) repeat (gap) @(negedge clk);
    end
  endtask

  // monitor: pops and compares each program request, then acknowledges
  initial begin
    expItem_t it;
    forever begin
      @(negedge clk);
      if (rstN && progReq) begin
        reqSeen++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R6", "unexpected request addr", 64'(progAddr), 64'h0);
        end else begin
          it = expQ.pop_front();
          chk(progAddr == it.addr, "R2", "request address", 64'(progAddr), 64'(it.addr));
          chk(progData == it.data, "R3", "request word", progData, it.data);
          chk(busy == 1'b1, "R2", "busy with request", 64'(busy), 64'h1);
          for (int k = 1; k < ackDelay; k++) begin
            @(negedge clk);
            chk(progReq && progData == it.data, "R8", "held word", progData, it.data);
          end
          monAck = 1'b1;
          @(negedge clk);
          monAck = 1'b0;
          chk(!progReq && !busy, "R8", "released after ack", 64'(progReq), 64'h0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!progReq && !busy && !err, "R1", "reset outputs", {61'h0, progReq, busy, err}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!progReq && !busy && !err, "R1", "after reset release", {61'h0, progReq, busy, err}, 64'h0);

    // R2 R3: group at bottom of window
    sendGroup(10'h200, 8'h10, 0);
    waitIdle();
    chk(err == 1'b0, "R2", "no error on clean group", 64'(err), 64'h0);

    // R7: gapped group at top of window
    sendGroup(10'h3F8, 8'hA0, 3);
    waitIdle();
    chk(err == 1'b0, "R7", "no error with gaps", 64'(err), 64'h0);

    // R4: unaligned opener
    wr(10'h203, 8'h55);
    chk(err == 1'b1, "R4", "unaligned sets err", 64'(err), 64'h1);
    chk(busy == 1'b0, "R4", "no group started", 64'(busy), 64'h0);
    clearErr();
    chk(err == 1'b0, "R10", "clear resets err", 64'(err), 64'h0);

    // R5: below window
    wr(10'h1F8, 8'h66);
    chk(err == 1'b1, "R5", "below window sets err", 64'(err), 64'h1);
    repeat (2) @(negedge clk);
    chk(err == 1'b1, "R10", "err sticky", 64'(err), 64'h1);
    clearErr();

    // R6: wrong address mid-group, then clean group
    wr(10'h240, 8'hE0); wr(10'h241, 8'hE1); wr(10'h242, 8'hE2);
    wr(10'h245, 8'hE5);
    chk(err == 1'b1, "R6", "mismatch sets err", 64'(err), 64'h1);
    clearErr();
    sendGroup(10'h240, 8'h01, 0);
    waitIdle();
    chk(reqSeen == 3, "R6", "dropped group made no request", 64'(reqSeen), 64'h3);

    // R9 R8: write while busy, delayed ack
    ackDelay = 6;
    sendGroup(10'h280, 8'h33, 0);
    wr(10'h288, 8'hFF);
    chk(err == 1'b1, "R9", "busy write sets err", 64'(err), 64'h1);
    waitIdle();
    ackDelay = 1;
    clearErr();

    // R10: error and clear on the same edge
    wrEn = 1'b1; wrAddr = 10'h301; wrData = 8'h00; errClr = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; errClr = 1'b0;
    chk(err == 1'b1, "R10", "error wins over clear", 64'(err), 64'h1);
    clearErr();

    // R11: stray ack mid gather and while idle
    strayAck = 1'b1;
    @(negedge clk);
    strayAck = 1'b0;
    chk(!progReq && !busy, "R11", "idle ack ignored", 64'(progReq), 64'h0);
    begin
      expItem_t it;
      it.addr = 10'h2C0;
      for (int i = 0; i < 8; i++) it.data[i*8 +: 8] = 8'hC0 + 8'(i);
      expQ.push_back(it);
      for (int i = 0; i < 3; i++) wr(10'h2C0 + 10'(i), it.data[i*8 +: 8]);
      strayAck = 1'b1;
      @(negedge clk);
      strayAck = 1'b0;
      for (int i = 3; i < 8; i++) wr(10'h2C0 + 10'(i), it.data[i*8 +: 8]);
    end
    waitIdle();
    chk(reqSeen == 5, "R11", "group completed after stray ack", 64'(reqSeen), 64'h5);
    chk(err == 1'b0, "R11", "no error from stray ack", 64'(err), 64'h0);
    chk(expQ.size() == 0, "R2", "scoreboard drained", 64'(expQ.size()), 64'h0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule